// File: doc/BRIEF.md
# Prescaled Reload Timer Pulse Generator

This block is a two-stage down-counting timer that produces a square wave. An 8-bit prescaler counts ticks of a selectable clock enable. Each time the prescaler runs past zero, an 8-bit main counter steps down by one. When the main counter runs past zero, the pulse level flips and a one-cycle interrupt request is raised. Each stage refills itself from its own reload register, so the wave repeats without software help.

Software reaches the block through three byte registers on a simple write/read bus. A control register selects the mode, the count source, run or stop, the starting polarity, whether the pin carries the pulse or a plain port value, and whether an inverted copy drives a second pin. The two count registers load the reload value and the live counter together, and reads return the live count. Control states: `ST_OFF` (mode not pulse), `ST_HOLD` (pulse mode, stopped), `ST_COUNT` (pulse mode, running). Transitions: ENABLE (`ST_OFF`→`ST_HOLD`, mode set to 01), START (`ST_HOLD`→`ST_COUNT`, run bit 1), STOP (`ST_COUNT`→`ST_HOLD`, run bit 0), DISABLE (any→`ST_OFF`, mode not 01). ENABLE and START may happen on the same write, going straight to `ST_COUNT`.

Top module: `pulse_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, both count registers (address 1 prescaler, address 2 main) read 0xFF, `irq` is 0, `pin_out` follows `port_bit` and `pin_n_out` is 0.
- R2: A write to address 1 or 2 loads that stage's reload register and its counter together, and a read of the same address right after returns the written value.
- R3: With prescaler setting n and main setting m, consecutive `irq` pulses are (n+1)(m+1)·D clock cycles apart, where D is 1, 2, 8 or 32 for control bits [7:6] = 00, 01, 10, 11.
- R4: `irq` is high for a single cycle per main-counter underflow, so it is low in the cycle after a pulse whenever the period exceeds one cycle.
- R5: The pulse level inverts at every main-counter underflow.
- R6: Control bit 2 picks the starting level (0 high, 1 low), and every write to address 2 returns the pulse level to that starting level.
- R7: With control bit 3 (run) at 0 both counters and the pulse level hold their values.
- R8: Unless control bits [1:0] equal 01, no counting happens and no `irq` is raised.
- R9: With control bit 4 at 1 and mode 01, `pin_out` carries the pulse level; otherwise `pin_out` follows `port_bit`.
- R10: With control bit 5 at 1 and mode 01, `pin_n_out` is the inverse of the pulse level; otherwise it is 0.
- R11: The prescaler steps down only on cycles where the selected source enable is active, and the main counter steps down only when the prescaler underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 prescaler, 2 main counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| port_bit | input | 1 | Plain port value driven on the pin when the pulse is not selected |
| pin_out | output | 1 | Pulse pin, or `port_bit` |
| pin_n_out | output | 1 | Inverted pulse when enabled, else 0 |
| irq | output | 1 | One-cycle interrupt request per main underflow |

## Verification
The bench measures the spacing of interrupt pulses for all four count sources and for edge settings such as a zero prescaler or zero main value; a design that reloaded one tick late, or decremented the main counter every source tick, would show a wrong spacing. It checks that the pulse level differs between consecutive interrupts and that a main-counter write snaps it back to the chosen starting level, which catches a missed toggle or an ignored polarity bit. Stop, wrong-mode and slow-source cases read the live counts back over the bus to show they hold or step at exactly the expected rate.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 2'd1;
    localparam logic [ADDR_W-1:0] A_MAIN  = 2'd2;

    localparam logic [1:0] MODE_PULSE = 2'b01;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_COUNT = 2'd2
    } pt_state_e;

    typedef struct packed {
        logic [1:0] src;
        logic       inv_en;
        logic       pin_sel;
        logic       run;
        logic       pol;
        logic [1:0] mode;
    } pt_ctrl_t;
endpackage

// File: rtl/pt_srcdiv.sv
module pt_srcdiv #(
    parameter int N_SRC  = 4,
    parameter int DIV_LG [N_SRC] = '{0, 1, 3, 5},
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [N_SRC-1:0] src_en
);
    logic [CNT_W-1:0] free_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_cnt <= '0;
        else        free_cnt <= free_cnt + 1'b1;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam logic [CNT_W-1:0] MASK = CNT_W'((1 << DIV_LG[g]) - 1);
        assign src_en[g] = ((free_cnt & MASK) == MASK);
    end
endmodule

// File: rtl/pt_stage.sv
module pt_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         underflow
);
    logic [W-1:0] reload_q;

    assign underflow = tick && !load && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '1;
            count    <= '1;
        end else if (load) begin
            reload_q <= load_val;
            count    <= load_val;
        end else if (tick) begin
            if (count == '0) count <= reload_q;
            else             count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import pt_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              port_bit,
    output logic              pin_out,
    output logic              pin_n_out,
    output logic              irq
);
    localparam int N_SRC = 4;

    pt_ctrl_t   ctrl_q;
    pt_state_e  state_q, state_d;
    logic [N_SRC-1:0] src_en;
    logic       count_en;
    logic       presc_wr, main_wr, ctrl_wr;
    logic       presc_tick, presc_uf, main_uf;
    logic [CNT_W-1:0] presc_cnt, main_cnt;
    logic       level_q, irq_q;
    logic       mode_ok;

    assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
    assign presc_wr = bus_we && (bus_addr == A_PRESC);
    assign main_wr  = bus_we && (bus_addr == A_MAIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= pt_ctrl_t'(bus_wdata);
    end

    assign mode_ok = (ctrl_q.mode == MODE_PULSE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (mode_ok) state_d = ctrl_q.run ? ST_COUNT : ST_HOLD;
            ST_HOLD:  if (!mode_ok) state_d = ST_OFF;
                      else if (ctrl_q.run) state_d = ST_COUNT;
            ST_COUNT: if (!mode_ok) state_d = ST_OFF;
                      else if (!ctrl_q.run) state_d = ST_HOLD;
            default:  state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign count_en = (state_q == ST_COUNT);

    pt_srcdiv #(.N_SRC(N_SRC)) i_srcdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_en (src_en)
    );

    assign presc_tick = count_en && src_en[ctrl_q.src];

    pt_stage #(.W(CNT_W)) i_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (presc_wr),
        .load_val  (bus_wdata[CNT_W-1:0]),
        .tick      (presc_tick),
        .count     (presc_cnt),
        .underflow (presc_uf)
    );

    pt_stage #(.W(CNT_W)) i_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (main_wr),
        .load_val  (bus_wdata[CNT_W-1:0]),
        .tick      (presc_uf),
        .count     (main_cnt),
        .underflow (main_uf)
    );

    // Output process: pulse level and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= main_uf;
            if (main_wr)      level_q <= !ctrl_q.pol;
            else if (main_uf) level_q <= !level_q;
        end
    end

    assign irq       = irq_q;
    assign pin_out   = (mode_ok && ctrl_q.pin_sel) ? level_q : port_bit;
    assign pin_n_out = mode_ok && ctrl_q.inv_en && !level_q;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_PRESC: bus_rdata = DATA_W'(presc_cnt);
            A_MAIN:  bus_rdata = DATA_W'(main_cnt);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             count_en,
    input logic             bus_we,
    input logic             main_wr,
    input logic             presc_uf,
    input logic [CNT_W-1:0] presc_cnt,
    input logic [CNT_W-1:0] main_cnt,
    input logic             level,
    input logic             pol,
    input logic             irq
);
    p_irq_needs_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(count_en))
        else $error("irq without counting");

    p_toggle_on_uf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(main_wr)) |-> (level != $past(level)))
        else $error("level did not invert on underflow");

    p_start_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(main_wr) |-> (level == !$past(pol)))
        else $error("main write did not restore start level");

    p_hold_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(count_en) && !$past(bus_we)) |->
            ($stable(presc_cnt) && $stable(main_cnt) && $stable(level)))
        else $error("state moved while stopped");

    p_main_steps_on_presc_uf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(main_cnt) && !$past(main_wr)) |-> $past(presc_uf))
        else $error("main counter moved without prescaler underflow");
endmodule

bind pulse_timer pt_checker #(.CNT_W(CNT_W)) i_pt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .bus_we    (bus_we),
    .main_wr   (main_wr),
    .presc_uf  (presc_uf),
    .presc_cnt (presc_cnt),
    .main_cnt  (main_cnt),
    .level     (level_q),
    .pol       (ctrl_q.pol),
    .irq       (irq)
);

// File: tb/test_pulse_timer.sv
`timescale 1ns/1ps
module test_pulse_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       port_bit = 1'b0;
    logic       pin_out, pin_n_out, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pulse_timer i_pulse_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_bit(port_bit),
        .pin_out(pin_out), .pin_n_out(pin_n_out), .irq(irq)
    );

    // {src[1:0], n[7:0], m[7:0], expected period[15:0]}
    localparam int NV = 7;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 8'd0, 8'd0, 16'd1},
        {2'd0, 8'd3, 8'd5, 16'd24},
        {2'd1, 8'd2, 8'd2, 16'd18},
        {2'd2, 8'd1, 8'd3, 16'd64},
        {2'd3, 8'd3, 8'd4, 16'd640},
        {2'd0, 8'd0, 8'd9, 16'd10},
        {2'd0, 8'd9, 8'd0, 16'd10}
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!irq && cyc < 5000);
    endtask

    // ctrl: [7:6] src, [5] inv_en, [4] pin_sel, [3] run, [2] pol, [1:0] mode
    function automatic logic [7:0] ctl(logic [1:0] src, logic inv, logic sel,
                                       logic run, logic pol, logic [1:0] mode);
        return {src, inv, sel, run, pol, mode};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, v2, m1;
        int cyc;
        logic lvl1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 presc", v, 8'hFF);
        rd(2'd2, v); check("R1 main", v, 8'hFF);
        check("R1 irq", irq, 0);
        port_bit = 1'b1; #1 check("R1 pin follows port", pin_out, 1);
        check("R1 pin_n", pin_n_out, 0);
        port_bit = 1'b0;

        // R2: write then read
        wr(2'd1, 8'h5A); rd(2'd1, v); check("R2 presc readback", v, 8'h5A);
        wr(2'd2, 8'h33); rd(2'd2, v); check("R2 main readback", v, 8'h33);

        // Vector table: R3 period, R4 single pulse, R5 toggle
        for (int i = 0; i < NV; i++) begin
            logic [1:0] s;
            s = VEC[i][33:32];
            wr(2'd0, ctl(s, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01));
            wr(2'd1, VEC[i][31:24]);
            wr(2'd2, VEC[i][23:16]);
            wr(2'd0, ctl(s, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01));
            wait_irq(cyc);
            lvl1 = pin_out;
            wait_irq(cyc);
            check($sformatf("R3 period vec%0d", i), cyc, int'(VEC[i][15:0]));
            check($sformatf("R5 toggle vec%0d", i), pin_out, !lvl1);
            if (VEC[i][15:0] > 1) begin
                @(negedge clk);
                check($sformatf("R4 single cycle vec%0d", i), irq, 0);
            end
        end

        // R6: start polarity and restore on main write
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01));
        wr(2'd2, 8'd10);
        check("R6 pol=1 starts low", pin_out, 0);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01));
        wr(2'd2, 8'd10);
        check("R6 pol=0 starts high", pin_out, 1);

        // R10: inverted companion
        wr(2'd0, ctl(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01));
        check("R10 inverse enabled", pin_n_out, 0);
        wr(2'd0, ctl(2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01));
        wr(2'd2, 8'd10);
        check("R10 inverse of low level", pin_n_out, 1);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01));
        check("R10 inverse disabled", pin_n_out, 0);

        // R9: pin select off -> port bit
        wr(2'd0, ctl(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01));
        port_bit = 1'b1; #1 check("R9 port bit 1", pin_out, 1);
        port_bit = 1'b0; #1 check("R9 port bit 0", pin_out, 0);

        // R7: stop holds counts and level
        wr(2'd1, 8'd9);
        wr(2'd2, 8'd200);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01));
        repeat (37) @(negedge clk);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01));
        repeat (2) @(negedge clk);
        rd(2'd1, v); rd(2'd2, m1); lvl1 = pin_out;
        repeat (20) @(negedge clk);
        rd(2'd1, v2); check("R7 presc held", v2, v);
        rd(2'd2, v2); check("R7 main held", v2, m1);
        check("R7 level held", pin_out, lvl1);
        check("R7 main moved before stop", (m1 < 8'd200) ? 1 : 0, 1);

        // R8: wrong mode -> no counting, no irq
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd0);
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10));
        cyc = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (irq) cyc++;
        end
        check("R8 no irq in wrong mode", cyc, 0);
        rd(2'd1, v); check("R8 presc idle", v, 0);
        port_bit = 1'b1; #1 check("R8/R9 pin is port bit", pin_out, 1);
        port_bit = 1'b0;

        // R11: prescaler steps at divide-by-8 rate, main waits for underflow
        wr(2'd0, ctl(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01));
        wr(2'd1, 8'd200);
        wr(2'd2, 8'd50);
        wr(2'd0, ctl(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01));
        repeat (4) @(negedge clk);
        rd(2'd1, v);
        repeat (32) @(negedge clk);
        rd(2'd1, v2);
        check("R11 presc steps per 32 cycles", int'(v) - int'(v2), 4);
        rd(2'd2, v2); check("R11 main unchanged", v2, 50);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule